// File: doc/BRIEF.md
# Fixed-Point Overflow Trap Unit

This unit follows the fixed-point ALU. Each finished arithmetic instruction hands it a result, an overflow flag, a flag for the divide class, a flag for the load-absolute/load-complement class, and two condition codes. One code is the value held before the instruction. The other is the code the ALU computed. The unit also receives the program status word, whose arithmetic trap mask it reads.

One cycle later the unit produces three things:
- a write-back enable for the destination register,
- the condition code to commit,
- a trap request to a fixed vector.

Two kinds of overflow are handled differently. A divide overflow suppresses the write-back and keeps most of the old condition code. Any other overflow completes the instruction and records the zero or sign state of the wrapped result, using the operand size of the instruction. The vector address is constant. The trap service sequence that consumes it is outside this unit.

Top module: `fxo_trap_unit`

## Requirements
- R1: While `rst` is high at a clock edge, `out_valid`, `out_wb`, `out_trap` and `out_cc` are all 0 after that edge.
- R2: For a valid instruction with `in_ovf`=0, the outputs one cycle later are `out_wb`=1, `out_cc`=`in_alu_cc` and `out_trap`=0.
- R3: For a valid overflowing instruction with `in_div`=0, `out_wb`=1 and CC2 (`out_cc[2]`) is 1.
- R4: For a valid non-divide overflow, CC3/CC4 (`out_cc[1:0]`) encode the wrapped result: 00 when it is zero, 01 when it is negative, 10 when it is positive.
- R5: The zero and sign tests of R4 use only the low bits given by `in_size`: 0 selects HALF_W bits, 1 selects WORD_W bits, 2 or 3 selects DBL_W bits. Bits above the selected width have no effect.
- R6: For a valid overflowing instruction with `in_div`=1, `out_wb`=0 and CC2 is 1. CC1, CC3 and CC4 equal the matching bits of `in_prev_cc`. This holds regardless of `in_ldabs`.
- R7: On a non-divide overflow, CC1 equals `in_prev_cc[3]` when `in_ldabs`=1 and is 0 otherwise.
- R8: `out_trap` is 1 exactly when a valid instruction overflowed and the trap mask is 1. The trap mask is PSW bit 11, counting from the MSB as bit 0, which is `in_psw[20]` for a 32-bit PSW. `out_trap_vec` is always 8'h43.
- R9: Outputs are registered one cycle after the input. After a cycle with `in_valid`=0, `out_valid`, `out_wb` and `out_trap` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | An instruction result is present |
| in_result | input | DBL_W | ALU result, right-aligned for the operand size |
| in_size | input | 2 | Operand size: 0 half, 1 word, 2/3 double |
| in_ovf | input | 1 | ALU reported fixed-point overflow |
| in_div | input | 1 | Instruction belongs to the divide class |
| in_ldabs | input | 1 | Instruction is a load-absolute or load-complement |
| in_prev_cc | input | 4 | Condition code before the instruction, bit 3 = CC1 |
| in_alu_cc | input | 4 | Condition code computed by the ALU |
| in_psw | input | PSW_W | Program status word holding the trap mask |
| out_valid | output | 1 | Verdict present |
| out_wb | output | 1 | Write the result to the destination register |
| out_cc | output | 4 | Condition code to commit |
| out_trap | output | 1 | Trap request |
| out_trap_vec | output | 8 | Trap vector address |

## Verification
The bench builds the unit with HALF_W=3, WORD_W=5 and DBL_W=8. The full 8-bit result space can then be swept for every size code and every combination of overflow, divide, load-class and mask flags. That sweep reaches every sign/zero boundary, including the most negative value and the all-ones value at each width. It also covers junk above the selected width, the reserved size code, and divide taking priority over the load class.

// File: rtl/fxo_pkg.sv
package fxo_pkg;

    typedef enum logic [1:0] {
        OPSZ_HALF   = 2'd0,
        OPSZ_WORD   = 2'd1,
        OPSZ_DOUBLE = 2'd2,
        OPSZ_RSVD   = 2'd3
    } opsz_e;

    typedef enum logic [1:0] {
        SGN_ZERO = 2'b00,
        SGN_NEG  = 2'b01,
        SGN_POS  = 2'b10
    } sgn_e;

    typedef struct packed {
        logic c1;
        logic c2;
        logic c3;
        logic c4;
    } cc_t;

    typedef struct packed {
        logic wb;
        cc_t  cc;
        logic trap;
    } verdict_t;

    localparam logic [7:0] FXO_TRAP_VECTOR = 8'h43;

    function automatic sgn_e sgn_code(input logic is_zero, input logic is_neg);
        if (is_zero)     return SGN_ZERO;
        else if (is_neg) return SGN_NEG;
        else             return SGN_POS;
    endfunction

endpackage

// File: rtl/fxo_size_sense.sv
module fxo_size_sense
    import fxo_pkg::*;
#(
    parameter int HALF_W = 16,
    parameter int WORD_W = 32,
    parameter int DBL_W  = 64
) (
    input  logic [DBL_W-1:0] result,
    input  opsz_e            size,
    output sgn_e             code
);
    localparam int NLANE = 3;

    function automatic int lane_width(input int idx);
        case (idx)
            0:       return HALF_W;
            1:       return WORD_W;
            default: return DBL_W;
        endcase
    endfunction

    logic [NLANE-1:0] lane_zero;
    logic [NLANE-1:0] lane_neg;

    for (genvar g = 0; g < NLANE; g++) begin : g_lane
        localparam int LW = lane_width(g);
        assign lane_zero[g] = (result[LW-1:0] == '0);
        assign lane_neg[g]  = result[LW-1];
    end

    always_comb begin
        unique case (size)
            OPSZ_HALF: code = sgn_code(lane_zero[0], lane_neg[0]);
            OPSZ_WORD: code = sgn_code(lane_zero[1], lane_neg[1]);
            default:   code = sgn_code(lane_zero[2], lane_neg[2]);
        endcase
    end
endmodule

// File: rtl/fxo_cc_merge.sv
module fxo_cc_merge
    import fxo_pkg::*;
(
    input  logic     ovf,
    input  logic     div,
    input  logic     ldabs,
    input  logic     mask,
    input  cc_t      prev_cc,
    input  cc_t      alu_cc,
    input  sgn_e     code,
    output verdict_t verdict
);
    always_comb begin
        verdict = '0;
        if (!ovf) begin
            verdict.wb   = 1'b1;
            verdict.cc   = alu_cc;
            verdict.trap = 1'b0;
        end else if (div) begin
            verdict.wb    = 1'b0;
            verdict.cc    = prev_cc;
            verdict.cc.c2 = 1'b1;
            verdict.trap  = mask;
        end else begin
            verdict.wb    = 1'b1;
            verdict.cc.c1 = ldabs ? prev_cc.c1 : 1'b0;
            verdict.cc.c2 = 1'b1;
            {verdict.cc.c3, verdict.cc.c4} = code;
            verdict.trap  = mask;
        end
    end
endmodule

// File: rtl/fxo_trap_unit.sv
module fxo_trap_unit
    import fxo_pkg::*;
#(
    parameter int HALF_W   = 16,
    parameter int WORD_W   = 32,
    parameter int DBL_W    = 64,
    parameter int PSW_W    = 32,
    parameter int MASK_BIT = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [DBL_W-1:0] in_result,
    input  logic [1:0]       in_size,
    input  logic             in_ovf,
    input  logic             in_div,
    input  logic             in_ldabs,
    input  logic [3:0]       in_prev_cc,
    input  logic [3:0]       in_alu_cc,
    input  logic [PSW_W-1:0] in_psw,
    output logic             out_valid,
    output logic             out_wb,
    output logic [3:0]       out_cc,
    output logic             out_trap,
    output logic [7:0]       out_trap_vec
);
    // PSW bits are numbered from the MSB as bit 0
    localparam int MASK_IDX = PSW_W - 1 - MASK_BIT;

    sgn_e     code;
    verdict_t verdict;

    fxo_size_sense #(
        .HALF_W (HALF_W),
        .WORD_W (WORD_W),
        .DBL_W  (DBL_W)
    ) u_sense (
        .result (in_result),
        .size   (opsz_e'(in_size)),
        .code   (code)
    );

    fxo_cc_merge u_merge (
        .ovf     (in_ovf),
        .div     (in_div),
        .ldabs   (in_ldabs),
        .mask    (in_psw[MASK_IDX]),
        .prev_cc (cc_t'(in_prev_cc)),
        .alu_cc  (cc_t'(in_alu_cc)),
        .code    (code),
        .verdict (verdict)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_wb    <= 1'b0;
            out_trap  <= 1'b0;
            out_cc    <= '0;
        end else begin
            out_valid <= in_valid;
            out_wb    <= in_valid & verdict.wb;
            out_trap  <= in_valid & verdict.trap;
            if (in_valid) out_cc <= verdict.cc;
        end
    end

    assign out_trap_vec = FXO_TRAP_VECTOR;

    a_r2_no_overflow: assert property (@(posedge clk) disable iff (rst)
        $past(!rst && in_valid && !in_ovf) |-> (out_wb && !out_trap && out_cc == $past(in_alu_cc)));

    a_r3_cc2_set: assert property (@(posedge clk) disable iff (rst)
        $past(!rst && in_valid && in_ovf && !in_div) |-> (out_wb && out_cc[2]));

    a_r6_div_abort: assert property (@(posedge clk) disable iff (rst)
        $past(!rst && in_valid && in_ovf && in_div) |->
            (!out_wb && out_cc == ($past(in_prev_cc) | 4'b0100)));

    a_r4_code_legal: assert property (@(posedge clk) disable iff (rst)
        $past(!rst && in_valid && in_ovf && !in_div) |-> (out_cc[1:0] != 2'b11));

    a_r8_trap_cause: assert property (@(posedge clk) disable iff (rst)
        out_trap |-> $past(in_valid && in_ovf && in_psw[MASK_IDX]));

    a_r9_idle: assert property (@(posedge clk) disable iff (rst)
        $past(!rst && !in_valid) |-> (!out_valid && !out_wb && !out_trap));
endmodule

// File: tb/fxo_trap_unit_tb.sv
module fxo_trap_unit_tb;
    localparam int CLK_PERIOD = 10;
    localparam int HW = 3, WW = 5, DW = 8, PW = 32;

    logic          clk = 1'b0;
    logic          rst;
    logic          in_valid, in_ovf, in_div, in_ldabs;
    logic [DW-1:0] in_result;
    logic [1:0]    in_size;
    logic [3:0]    in_prev_cc, in_alu_cc;
    logic [PW-1:0] in_psw;
    logic          out_valid, out_wb, out_trap;
    logic [3:0]    out_cc;
    logic [7:0]    out_trap_vec;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fxo_trap_unit #(.HALF_W(HW), .WORD_W(WW), .DBL_W(DW), .PSW_W(PW), .MASK_BIT(11)) u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_result(in_result),
        .in_size(in_size), .in_ovf(in_ovf), .in_div(in_div), .in_ldabs(in_ldabs),
        .in_prev_cc(in_prev_cc), .in_alu_cc(in_alu_cc), .in_psw(in_psw),
        .out_valid(out_valid), .out_wb(out_wb), .out_cc(out_cc),
        .out_trap(out_trap), .out_trap_vec(out_trap_vec)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; in_valid = 1'b1; in_ovf = 1'b1; in_div = 1'b0; in_ldabs = 1'b0;
        in_result = '1; in_size = 2'd0; in_prev_cc = 4'hF; in_alu_cc = 4'hF; in_psw = '1;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 valid", {7'b0, out_valid}, 8'h0);
        chk("R1 wb",    {7'b0, out_wb},    8'h0);
        chk("R1 trap",  {7'b0, out_trap},  8'h0);
        chk("R1 cc",    {4'b0, out_cc},    8'h0);
        rst = 1'b0;
        in_valid = 1'b0;
        @(negedge clk);
        // R9: idle gives no verdict
        chk("R9 idle valid", {7'b0, out_valid}, 8'h0);
        chk("R8 vector", out_trap_vec, 8'h43);

        for (int sz = 0; sz < 4; sz++) begin
            for (int v = 0; v < 256; v++) begin
                for (int f = 0; f < 16; f++) begin
                    automatic int w = (sz == 0) ? HW : (sz == 1) ? WW : DW;
                    automatic int mv = v & ((1 << w) - 1);
                    automatic bit ovf = f[0], dv = f[1], la = f[2], mk = f[3];
                    automatic logic [3:0] pcc = 4'((v ^ (f * 3)) & 15);
                    automatic logic [3:0] acc = 4'((v * 7 + sz + f) & 15);
                    automatic logic [1:0] code;
                    automatic logic [3:0] ecc;
                    automatic logic ewb, etr;
                    automatic logic [PW-1:0] psw = PW'(v * 32'h9E3779B1 + f);
                    psw[20] = mk;
                    if (mv == 0) code = 2'b00;
                    else if (((mv >> (w - 1)) & 1) == 1) code = 2'b01;
                    else code = 2'b10;
                    if (!ovf) begin
                        ewb = 1; ecc = acc; etr = 0;
                    end else if (dv) begin
                        ewb = 0; ecc = {pcc[3], 1'b1, pcc[1:0]}; etr = mk;
                    end else begin
                        ewb = 1; ecc = {la ? pcc[3] : 1'b0, 1'b1, code}; etr = mk;
                    end
                    in_valid = 1'b1; in_result = 8'(v); in_size = 2'(sz);
                    in_ovf = ovf; in_div = dv; in_ldabs = la;
                    in_prev_cc = pcc; in_alu_cc = acc; in_psw = psw;
                    @(negedge clk);
                    chk("R9 valid", {7'b0, out_valid}, 8'h1);
                    if (!ovf) begin
                        chk("R2 cc/wb/trap", {out_wb, out_trap, 2'b0, out_cc}, {ewb, etr, 2'b0, ecc});
                    end else if (dv) begin
                        chk("R6 div abort", {out_wb, 3'b0, out_cc}, {ewb, 3'b0, ecc});
                        chk("R8 trap div", {7'b0, out_trap}, {7'b0, etr});
                    end else begin
                        chk("R3 wb+CC2", {6'b0, out_wb, out_cc[2]}, {6'b0, ewb, 1'b1});
                        chk("R4 R5 sign code", {6'b0, out_cc[1:0]}, {6'b0, ecc[1:0]});
                        chk("R7 CC1", {7'b0, out_cc[3]}, {7'b0, ecc[3]});
                        chk("R8 trap", {7'b0, out_trap}, {7'b0, etr});
                    end
                end
            end
        end

        // R9: after idle cycle everything drops
        in_valid = 1'b0; in_ovf = 1'b1; in_psw = '1;
        @(negedge clk);
        chk("R9 idle after traffic", {5'b0, out_valid, out_wb, out_trap}, 8'h0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule